// File: doc/BRIEF.md
# Dual-Bank IN Endpoint Transmit Controller

This block tracks the ping-pong transmit buffers of one device-side IN endpoint. Firmware fills the bank named by the current-bank output. It programs that bank's byte count and then hands the bank over with a release strobe. The link side is offered the oldest committed bank together with its length. It starts sending that bank and later reports that the host has taken the packet. With two banks, firmware can fill one bank while the other is being sent.

A transmit-ready flag tells firmware that the current bank is free, and an enable gates it onto the interrupt line. Firmware clears the flag to acknowledge the interrupt, and this does not change bank ownership. A kill command takes back the most recently committed bank that has not yet been sent. An endpoint-reset strobe empties both banks. The link can also flag an abort when a zero-length OUT arrives during the IN data stage. Firmware recovers from that case by disabling the interrupt and then killing banks, or resetting the endpoint, until the busy count reaches zero.

Top module: `in_ep_bank_ctrl`

## Requirements
- R1: `fw_irq` is high exactly when `fw_tx_rdy` and the interrupt enable are both high. `fw_ie_set` sets the enable and `fw_ie_clr` clears it; set wins if both are high in the same cycle. The enable is 0 after reset.
- R2: `fw_rdy_ack` clears `fw_tx_rdy` in the next cycle unless a free-bank event happens in the same cycle. It leaves `fw_own`, `fw_cur_bank` and `fw_busy_cnt` unchanged.
- R3: `fw_cur_bank` is 0 after reset. Each accepted release moves it to the other bank when two banks are configured.
- R4: `fw_cnt_we` writes `fw_cnt_val` into the byte count of the bank selected by `fw_cnt_bank`. `lnk_len` always shows the byte count of the bank named on `lnk_bank`.
- R5: A release is accepted only while `fw_own` is 1 (the current bank is free) and no kill is pending. An accepted release marks the bank busy, and `fw_busy_cnt` rises by one in the next cycle. A release at any other time has no effect.
- R6: When a release is accepted and the next bank is already free, `fw_tx_rdy` and `fw_own` are both 1 in the next cycle. A free-bank event also happens when a busy current bank becomes free.
- R7: Banks are offered on `lnk_bank` in commit order. `lnk_valid` is high while that bank is busy, is not already being sent, and is not the target of a pending kill. `lnk_start` is accepted only while `lnk_valid` is high. `lnk_done` is accepted only while a send is in progress; it frees the bank and lowers `fw_busy_cnt` by one.
- R8: `fw_kill_req` with a nonzero busy count sets `fw_kill_pend` in the next cycle. If the most recently committed bank is not being sent, it is released one cycle later. At that point `fw_kill_pend` clears, the busy count drops by one, `fw_cur_bank` points at the freed bank and `fw_tx_rdy` is set.
- R9: If the kill target is being sent, no bank is retracted and `fw_kill_pend` stays high until the send completes. It clears in the cycle after `lnk_done`. A kill request with a busy count of zero is ignored.
- R10: `fw_ep_reset` leaves both banks free, the busy count at 0, the current bank at 0, no kill pending, no send in progress, and `fw_tx_rdy` set. The reset pin produces the same state, and it also clears the byte counts, the enable and the abort flag.
- R11: For control or isochronous endpoints, `lnk_zlp_out` while `lnk_in_stage` is high sets `fw_abort` in the next cycle. `fw_abort_ack` clears it, and setting wins over clearing. `lnk_zlp_out` outside the IN stage leaves `fw_abort` unchanged.
- R12: `fw_busy_cnt` never exceeds the number of configured banks and never decrements below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_cnt_we | input | 1 | Byte-count write strobe |
| fw_cnt_bank | input | 1 | Bank selected for the byte-count write |
| fw_cnt_val | input | CNT_W | Byte count to write |
| fw_release | input | 1 | Hand the current bank to the link side |
| fw_rdy_ack | input | 1 | Clear the transmit-ready flag |
| fw_ie_set | input | 1 | Enable the transmit-ready interrupt |
| fw_ie_clr | input | 1 | Disable the transmit-ready interrupt |
| fw_kill_req | input | 1 | Retract the most recently committed bank |
| fw_ep_reset | input | 1 | Endpoint reset strobe |
| fw_abort_ack | input | 1 | Clear the abort flag |
| fw_cur_bank | output | 1 | Bank firmware should fill |
| fw_busy_cnt | output | 2 | Number of committed, unsent banks |
| fw_tx_rdy | output | 1 | Transmit-ready flag |
| fw_own | output | 1 | Current bank is free and owned by firmware |
| fw_kill_pend | output | 1 | Kill in progress |
| fw_irq_en | output | 1 | Interrupt enable state |
| fw_irq | output | 1 | Endpoint interrupt |
| fw_abort | output | 1 | Abort condition flag |
| lnk_valid | output | 1 | A committed bank is ready to send |
| lnk_bank | output | 1 | Bank offered to the link |
| lnk_len | output | CNT_W | Byte count of the offered bank |
| lnk_start | input | 1 | Link begins sending the offered bank |
| lnk_done | input | 1 | Host has taken the packet in flight |
| lnk_zlp_out | input | 1 | Zero-length OUT seen |
| lnk_in_stage | input | 1 | An IN data stage is in progress |

## Verification
The first directed pattern fills and releases both banks back to back. It separates an immediate re-raise of transmit-ready from a late one, and commit-order sending from a pointer that follows the fill side. Kills are tried in three situations: with two banks busy and neither in flight, with the only busy bank in flight, and with nothing busy. These cases separate a retraction from a deferred no-op and from an ignored request. A long pseudo-random run then mixes releases, acknowledges, kills, link starts and completions, and rare endpoint resets. It covers same-cycle collisions that the directed cases miss, such as a release together with a completion or a kill together with a release.

// File: rtl/in_ep_pkg.sv
// Package: shared types for the IN endpoint bank controller.
// Assumes: endpoint kind is fixed at elaboration time.
package in_ep_pkg;
    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_kind_e;
endpackage

// File: rtl/in_ep_cnt_regs.sv
// Module: per-bank byte-count registers with a read mux for the link side.
// Assumes: one or two banks; writes to a bank that is not configured are dropped.
module in_ep_cnt_regs #(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             rd_bank,
    output logic [CNT_W-1:0] rd_len
);
    localparam int SLOTS = 2;

    logic [SLOTS*CNT_W-1:0] cnt_flat;

    for (genvar b = 0; b < SLOTS; b++) begin : g_bank
        if (b < NUM_BANKS) begin : g_real
            logic [CNT_W-1:0] cnt_q;
            // Capture a firmware byte count aimed at this bank.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (wr_en && (wr_bank == b[0])) begin
                    cnt_q <= wr_val;
                end
            end
            assign cnt_flat[b*CNT_W +: CNT_W] = cnt_q;
        end else begin : g_absent
            assign cnt_flat[b*CNT_W +: CNT_W] = '0;
        end
    end

    // Select the length of the bank on offer.
    always_comb begin
        rd_len = rd_bank ? cnt_flat[CNT_W +: CNT_W] : cnt_flat[0 +: CNT_W];
    end
endmodule

// File: rtl/in_ep_bank_fsm.sv
// Module: bank ownership tracker. It holds the busy bit of each bank, the fill
// and send pointers, the in-flight flag and the kill sequencer. It also reports
// a free-bank event when the current bank becomes available to firmware.
// Assumes: strobes are single-cycle and synchronous; the endpoint reset wins over
// everything else.
module in_ep_bank_fsm #(
    parameter int NUM_BANKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ep_reset,
    input  logic       release_req,
    input  logic       kill_req,
    input  logic       lnk_start,
    input  logic       lnk_done,
    output logic       cur_bank,
    output logic       snd_bank,
    output logic [1:0] busy_cnt,
    output logic       own,
    output logic       kill_pend,
    output logic       offer,
    output logic       rdy_evt
);
    localparam bit HAS_PAIR = (NUM_BANKS == 2);

    logic [1:0] busy_q, busy_n;
    logic       cur_q, cur_n;
    logic       snd_q, snd_n;
    logic       sending_q, sending_n;
    logic       kill_q, kill_n;

    logic last_bank;
    logic commit, start_acc, done_acc;
    logic kill_block, kill_exec, kill_noop, kill_accept;
    logic own_n;

    // Decode the accepted commands from the current state.
    always_comb begin
        last_bank   = HAS_PAIR ? ~cur_q : 1'b0;
        own         = ~busy_q[cur_q];
        commit      = release_req && own && !kill_q;
        offer       = busy_q[snd_q] && !sending_q && !(kill_q && (snd_q == last_bank));
        start_acc   = lnk_start && offer;
        done_acc    = lnk_done && sending_q;
        kill_block  = kill_q && sending_q && (snd_q == last_bank);
        kill_exec   = kill_q && busy_q[last_bank] && !kill_block;
        kill_noop   = kill_q && !busy_q[last_bank];
        kill_accept = kill_req && !kill_q && (busy_q != 2'b00);
    end

    // Work out the next bank state from the accepted commands.
    always_comb begin
        busy_n    = busy_q;
        cur_n     = cur_q;
        snd_n     = snd_q;
        sending_n = sending_q;
        kill_n    = kill_q;
        if (commit) begin
            busy_n[cur_q] = 1'b1;
            cur_n         = HAS_PAIR ? ~cur_q : 1'b0;
        end
        if (start_acc) begin
            sending_n = 1'b1;
        end
        if (done_acc) begin
            busy_n[snd_q] = 1'b0;
            snd_n         = HAS_PAIR ? ~snd_q : 1'b0;
            sending_n     = 1'b0;
        end
        if (kill_exec) begin
            busy_n[last_bank] = 1'b0;
            cur_n             = last_bank;
            kill_n            = 1'b0;
        end
        if (kill_noop) begin
            kill_n = 1'b0;
        end
        if (kill_accept) begin
            kill_n = 1'b1;
        end
        if (ep_reset) begin
            busy_n    = 2'b00;
            cur_n     = 1'b0;
            snd_n     = 1'b0;
            sending_n = 1'b0;
            kill_n    = 1'b0;
        end
        own_n   = ~busy_n[cur_n];
        rdy_evt = own_n && (!own || commit || kill_exec);
    end

    // Register the bank state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 2'b00;
            cur_q     <= 1'b0;
            snd_q     <= 1'b0;
            sending_q <= 1'b0;
            kill_q    <= 1'b0;
        end else begin
            busy_q    <= busy_n;
            cur_q     <= cur_n;
            snd_q     <= snd_n;
            sending_q <= sending_n;
            kill_q    <= kill_n;
        end
    end

    // Drive the busy count and the pointers out.
    always_comb begin
        busy_cnt  = {1'b0, busy_q[0]} + {1'b0, busy_q[1]};
        cur_bank  = cur_q;
        snd_bank  = snd_q;
        kill_pend = kill_q;
    end

    AST_COMMIT_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !done_acc && !ep_reset) |=> (busy_cnt == $past(busy_cnt) + 2'd1))
        else $error("commit did not raise busy count"); // R5

    AST_DONE_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && !commit && !kill_exec && !ep_reset) |=> (busy_cnt == $past(busy_cnt) - 2'd1))
        else $error("completion did not lower busy count"); // R7

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt <= 2'(NUM_BANKS)))
        else $error("busy count beyond bank count"); // R12

    AST_EP_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ep_reset |=> (busy_cnt == 2'd0 && cur_bank == 1'b0 && !kill_pend))
        else $error("endpoint reset left state behind"); // R10

    AST_KILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_block && !ep_reset) |=> kill_pend)
        else $error("kill cleared while target in flight"); // R9
endmodule

// File: rtl/in_ep_fw_flags.sv
// Module: firmware-visible flags: transmit-ready, interrupt enable, interrupt
// line and the abort flag.
// Assumes: the free-bank event comes from the bank tracker; the abort detector
// exists only for control and isochronous endpoints.
module in_ep_fw_flags
    import in_ep_pkg::*;
#(
    parameter ep_kind_e EP_KIND = EP_CTRL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ep_reset,
    input  logic rdy_evt,
    input  logic rdy_ack,
    input  logic ie_set,
    input  logic ie_clr,
    input  logic zlp_out,
    input  logic in_stage,
    input  logic abort_ack,
    output logic tx_rdy,
    output logic irq_en,
    output logic irq,
    output logic abort_flag
);
    localparam bit ABORT_CAPABLE = (EP_KIND == EP_CTRL) || (EP_KIND == EP_ISO);

    logic rdy_q, ie_q;

    // Transmit-ready: set on a free-bank event, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b1;
        end else if (ep_reset || rdy_evt) begin
            rdy_q <= 1'b1;
        end else if (rdy_ack) begin
            rdy_q <= 1'b0;
        end
    end

    // Interrupt enable with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (ie_set) begin
            ie_q <= 1'b1;
        end else if (ie_clr) begin
            ie_q <= 1'b0;
        end
    end

    if (ABORT_CAPABLE) begin : g_abort
        logic ab_q;
        // Latch a zero-length OUT seen during the IN data stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ab_q <= 1'b0;
            end else if (zlp_out && in_stage) begin
                ab_q <= 1'b1;
            end else if (abort_ack) begin
                ab_q <= 1'b0;
            end
        end
        assign abort_flag = ab_q;

        AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (zlp_out && in_stage) |=> abort_flag)
            else $error("abort not flagged"); // R11
    end else begin : g_no_abort
        assign abort_flag = 1'b0;
    end

    // Combine flag and enable into the interrupt line.
    always_comb begin
        tx_rdy = rdy_q;
        irq_en = ie_q;
        irq    = rdy_q && ie_q;
    end

    AST_ACK_DROPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_ack && !rdy_evt && !ep_reset) |=> !tx_rdy)
        else $error("acknowledge did not clear ready"); // R2

    AST_EP_RESET_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        ep_reset |=> tx_rdy)
        else $error("endpoint reset did not raise ready"); // R10
endmodule

// File: rtl/in_ep_bank_ctrl.sv
// Module: top of the dual-bank IN endpoint transmit controller. It ties the
// byte-count registers, the bank tracker and the firmware flags together.
// Assumes: one clock domain; all firmware and link strobes are single-cycle pulses.
module in_ep_bank_ctrl
    import in_ep_pkg::*;
#(
    parameter int       NUM_BANKS = 2,
    parameter int       CNT_W     = 11,
    parameter ep_kind_e EP_KIND   = EP_CTRL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fw_cnt_we,
    input  logic             fw_cnt_bank,
    input  logic [CNT_W-1:0] fw_cnt_val,
    input  logic             fw_release,
    input  logic             fw_rdy_ack,
    input  logic             fw_ie_set,
    input  logic             fw_ie_clr,
    input  logic             fw_kill_req,
    input  logic             fw_ep_reset,
    input  logic             fw_abort_ack,
    output logic             fw_cur_bank,
    output logic [1:0]       fw_busy_cnt,
    output logic             fw_tx_rdy,
    output logic             fw_own,
    output logic             fw_kill_pend,
    output logic             fw_irq_en,
    output logic             fw_irq,
    output logic             fw_abort,
    output logic             lnk_valid,
    output logic             lnk_bank,
    output logic [CNT_W-1:0] lnk_len,
    input  logic             lnk_start,
    input  logic             lnk_done,
    input  logic             lnk_zlp_out,
    input  logic             lnk_in_stage
);
    logic rdy_evt;

    in_ep_cnt_regs #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (CNT_W)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fw_cnt_we),
        .wr_bank (fw_cnt_bank),
        .wr_val  (fw_cnt_val),
        .rd_bank (lnk_bank),
        .rd_len  (lnk_len)
    );

    in_ep_bank_fsm #(
        .NUM_BANKS (NUM_BANKS)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ep_reset    (fw_ep_reset),
        .release_req (fw_release),
        .kill_req    (fw_kill_req),
        .lnk_start   (lnk_start),
        .lnk_done    (lnk_done),
        .cur_bank    (fw_cur_bank),
        .snd_bank    (lnk_bank),
        .busy_cnt    (fw_busy_cnt),
        .own         (fw_own),
        .kill_pend   (fw_kill_pend),
        .offer       (lnk_valid),
        .rdy_evt     (rdy_evt)
    );

    in_ep_fw_flags #(
        .EP_KIND (EP_KIND)
    ) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ep_reset   (fw_ep_reset),
        .rdy_evt    (rdy_evt),
        .rdy_ack    (fw_rdy_ack),
        .ie_set     (fw_ie_set),
        .ie_clr     (fw_ie_clr),
        .zlp_out    (lnk_zlp_out),
        .in_stage   (lnk_in_stage),
        .abort_ack  (fw_abort_ack),
        .tx_rdy     (fw_tx_rdy),
        .irq_en     (fw_irq_en),
        .irq        (fw_irq),
        .abort_flag (fw_abort)
    );
endmodule

// File: tb/in_ep_bank_ctrl_tb_top.sv
module in_ep_bank_ctrl_tb_top;
    localparam int CNT_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fw_cnt_we = 0, fw_cnt_bank = 0;
    logic [CNT_W-1:0] fw_cnt_val = '0;
    logic             fw_release = 0, fw_rdy_ack = 0, fw_ie_set = 0, fw_ie_clr = 0;
    logic             fw_kill_req = 0, fw_ep_reset = 0, fw_abort_ack = 0;
    logic             lnk_start = 0, lnk_done = 0, lnk_zlp_out = 0, lnk_in_stage = 0;
    logic             fw_cur_bank, fw_tx_rdy, fw_own, fw_kill_pend, fw_irq_en, fw_irq, fw_abort;
    logic [1:0]       fw_busy_cnt;
    logic             lnk_valid, lnk_bank;
    logic [CNT_W-1:0] lnk_len;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    in_ep_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .fw_cnt_we(fw_cnt_we), .fw_cnt_bank(fw_cnt_bank), .fw_cnt_val(fw_cnt_val),
        .fw_release(fw_release), .fw_rdy_ack(fw_rdy_ack),
        .fw_ie_set(fw_ie_set), .fw_ie_clr(fw_ie_clr),
        .fw_kill_req(fw_kill_req), .fw_ep_reset(fw_ep_reset), .fw_abort_ack(fw_abort_ack),
        .fw_cur_bank(fw_cur_bank), .fw_busy_cnt(fw_busy_cnt), .fw_tx_rdy(fw_tx_rdy),
        .fw_own(fw_own), .fw_kill_pend(fw_kill_pend), .fw_irq_en(fw_irq_en),
        .fw_irq(fw_irq), .fw_abort(fw_abort),
        .lnk_valid(lnk_valid), .lnk_bank(lnk_bank), .lnk_len(lnk_len),
        .lnk_start(lnk_start), .lnk_done(lnk_done),
        .lnk_zlp_out(lnk_zlp_out), .lnk_in_stage(lnk_in_stage)
    );

    // Behavioural reference: busy flags per bank, a fill pointer, a send pointer.
    int m_busy[2];
    int m_cnt[2];
    int m_cur, m_snd, m_send, m_kill, m_rdy, m_ie, m_ab;
    int t_last, t_own, t_com, t_val, t_blk, t_kex, t_knop, t_kacc, t_done, t_start, t_nown;

    function automatic int exp_valid();
        int lb = 1 - m_cur;
        return (m_busy[m_snd] != 0 && m_send == 0 && !(m_kill != 0 && m_snd == lb)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy[0] = 0; m_busy[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
            m_cur = 0; m_snd = 0; m_send = 0; m_kill = 0; m_rdy = 1; m_ie = 0; m_ab = 0;
        end else begin
            t_last  = 1 - m_cur;
            t_own   = (m_busy[m_cur] == 0) ? 1 : 0;
            t_com   = (fw_release && t_own != 0 && m_kill == 0) ? 1 : 0;
            t_val   = exp_valid();
            t_start = (lnk_start && t_val != 0) ? 1 : 0;
            t_done  = (lnk_done && m_send != 0) ? 1 : 0;
            t_blk   = (m_kill != 0 && m_send != 0 && m_snd == t_last) ? 1 : 0;
            t_kex   = (m_kill != 0 && m_busy[t_last] != 0 && t_blk == 0) ? 1 : 0;
            t_knop  = (m_kill != 0 && m_busy[t_last] == 0) ? 1 : 0;
            t_kacc  = (fw_kill_req && m_kill == 0 && (m_busy[0] + m_busy[1]) > 0) ? 1 : 0;
            if (fw_cnt_we) m_cnt[fw_cnt_bank] = int'(fw_cnt_val);
            if (fw_ie_set) m_ie = 1; else if (fw_ie_clr) m_ie = 0;
            if (lnk_zlp_out && lnk_in_stage) m_ab = 1; else if (fw_abort_ack) m_ab = 0;
            if (t_com != 0) begin m_busy[m_cur] = 1; m_cur = 1 - m_cur; end
            if (t_start != 0) m_send = 1;
            if (t_done != 0) begin m_busy[m_snd] = 0; m_snd = 1 - m_snd; m_send = 0; end
            if (t_kex != 0) begin m_busy[t_last] = 0; m_cur = t_last; m_kill = 0; end
            if (t_knop != 0) m_kill = 0;
            if (t_kacc != 0) m_kill = 1;
            if (fw_ep_reset) begin
                m_busy[0] = 0; m_busy[1] = 0; m_cur = 0; m_snd = 0; m_send = 0; m_kill = 0;
            end
            t_nown = (m_busy[m_cur] == 0) ? 1 : 0;
            if (fw_ep_reset || (t_nown != 0 && (t_own == 0 || t_com != 0 || t_kex != 0)))
                m_rdy = 1;
            else if (fw_rdy_ack)
                m_rdy = 0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the reference model.
    task automatic cmp_all();
        chk("R3", "cur_bank", int'(fw_cur_bank), m_cur);
        chk("R12", "busy_cnt", int'(fw_busy_cnt), m_busy[0] + m_busy[1]);
        chk("R2", "tx_rdy", int'(fw_tx_rdy), m_rdy);
        chk("R5", "own", int'(fw_own), (m_busy[m_cur] == 0) ? 1 : 0);
        chk("R1", "irq", int'(fw_irq), (m_rdy != 0 && m_ie != 0) ? 1 : 0);
        chk("R1", "irq_en", int'(fw_irq_en), m_ie);
        chk("R8", "kill_pend", int'(fw_kill_pend), m_kill);
        chk("R7", "lnk_valid", int'(lnk_valid), exp_valid());
        chk("R7", "lnk_bank", int'(lnk_bank), m_snd);
        chk("R4", "lnk_len", int'(lnk_len), m_cnt[m_snd]);
        chk("R11", "abort", int'(fw_abort), m_ab);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) cmp_all();
    endtask

    task automatic clr_in();
        fw_cnt_we = 0; fw_release = 0; fw_rdy_ack = 0; fw_ie_set = 0; fw_ie_clr = 0;
        fw_kill_req = 0; fw_ep_reset = 0; fw_abort_ack = 0;
        lnk_start = 0; lnk_done = 0; lnk_zlp_out = 0;
    endtask

    task automatic wr_cnt(input int bank, input int val);
        fw_cnt_we = 1; fw_cnt_bank = bank[0]; fw_cnt_val = CNT_W'(val);
        tick(); clr_in();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 R3: reset state
        chk("R10", "rst tx_rdy", int'(fw_tx_rdy), 1);
        chk("R3", "rst cur", int'(fw_cur_bank), 0);
        chk("R10", "rst busy", int'(fw_busy_cnt), 0);
        chk("R1", "rst irq", int'(fw_irq), 0);
        // R1: enable raises the interrupt
        fw_ie_set = 1; tick(); clr_in();
        chk("R1", "irq after enable", int'(fw_irq), 1);
        // R2: acknowledge keeps ownership
        fw_rdy_ack = 1; tick(); clr_in();
        chk("R2", "rdy after ack", int'(fw_tx_rdy), 0);
        chk("R2", "own after ack", int'(fw_own), 1);
        // R4 R6 R7: fill bank 0 and release
        wr_cnt(0, 5);
        fw_release = 1; tick(); clr_in();
        chk("R3", "cur after release", int'(fw_cur_bank), 1);
        chk("R6", "rdy again", int'(fw_tx_rdy), 1);
        chk("R7", "offer bank0", int'(lnk_valid), 1);
        chk("R4", "len bank0", int'(lnk_len), 5);
        // R5: second bank, then a release with nothing free is ignored
        wr_cnt(1, 9);
        fw_release = 1; tick(); clr_in();
        chk("R5", "busy two", int'(fw_busy_cnt), 2);
        chk("R5", "own none", int'(fw_own), 0);
        fw_release = 1; tick(); clr_in();
        chk("R5", "extra release ignored", int'(fw_busy_cnt), 2);
        // R8: kill the newer bank (bank 1)
        fw_kill_req = 1; tick(); clr_in();
        chk("R8", "kill pending", int'(fw_kill_pend), 1);
        tick();
        chk("R8", "kill done", int'(fw_kill_pend), 0);
        chk("R8", "busy after kill", int'(fw_busy_cnt), 1);
        chk("R8", "cur to killed bank", int'(fw_cur_bank), 1);
        // R9: kill while the only busy bank is in flight
        lnk_start = 1; tick(); clr_in();
        fw_kill_req = 1; tick(); clr_in();
        repeat (3) tick();
        chk("R9", "kill waits", int'(fw_kill_pend), 1);
        chk("R9", "no retraction", int'(fw_busy_cnt), 1);
        lnk_done = 1; tick(); clr_in();
        chk("R9", "busy after send", int'(fw_busy_cnt), 0);
        chk("R9", "still pending", int'(fw_kill_pend), 1);
        tick();
        chk("R9", "pending cleared", int'(fw_kill_pend), 0);
        fw_kill_req = 1; tick(); clr_in();
        chk("R9", "kill on empty ignored", int'(fw_kill_pend), 0);
        // R11: abort flag
        lnk_zlp_out = 1; tick(); clr_in();
        chk("R11", "zlp outside stage", int'(fw_abort), 0);
        lnk_in_stage = 1; lnk_zlp_out = 1; tick(); clr_in(); lnk_in_stage = 0;
        chk("R11", "abort set", int'(fw_abort), 1);
        fw_abort_ack = 1; tick(); clr_in();
        chk("R11", "abort cleared", int'(fw_abort), 0);
        // R10: endpoint reset after a commit
        fw_release = 1; tick(); clr_in();
        fw_ep_reset = 1; tick(); clr_in();
        chk("R10", "ep reset busy", int'(fw_busy_cnt), 0);
        chk("R10", "ep reset cur", int'(fw_cur_bank), 0);
        chk("R10", "ep reset rdy", int'(fw_tx_rdy), 1);
        // Mixed pseudo-random traffic, compared every cycle (all requirements).
        for (int i = 0; i < 6000; i++) begin
            fw_release   = ($urandom_range(0, 3) == 0);
            fw_rdy_ack   = ($urandom_range(0, 3) == 0);
            fw_ie_set    = ($urandom_range(0, 15) == 0);
            fw_ie_clr    = ($urandom_range(0, 15) == 0);
            fw_kill_req  = ($urandom_range(0, 15) == 0);
            fw_ep_reset  = ($urandom_range(0, 63) == 0);
            fw_abort_ack = ($urandom_range(0, 7) == 0);
            fw_cnt_we    = ($urandom_range(0, 2) == 0);
            fw_cnt_bank  = 1'($urandom_range(0, 1));
            fw_cnt_val   = CNT_W'($urandom_range(0, 2047));
            lnk_start    = ($urandom_range(0, 2) == 0);
            lnk_done     = ($urandom_range(0, 3) == 0);
            lnk_zlp_out  = ($urandom_range(0, 15) == 0);
            lnk_in_stage = 1'($urandom_range(0, 1));
            tick();
        end
        clr_in();
        tick();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule